// File: doc/BRIEF.md
# Floppy Controller I/O Port Bank

This block sits between a host I/O bus and the core of a floppy disk controller. It decodes five byte-wide I/O addresses. Status and data accesses pass straight through to the controller core. A reset-control port raises a reset request toward the core, and two further ports hold the drive mode flags: one global flag for the media density and one access-mode flag for each drive.

Reads are combinational. `bus_rdata` reflects the addressed port in the same cycle that `bus_addr` and `bus_rd` are presented. Writes take effect at the next rising clock edge. The data strobes toward the core are the bus strobes qualified by the data-port decode. The reset request to the core is a registered single-cycle pulse. The core uses it both to reset itself and to leave its power-down state. The mode flags are exported so that the drive interface logic can pick its rates.

The per-drive flag port uses a select-and-enable encoding. Every write to it moves the drive select. Only writes that also carry the enable bit change a flag, and the flag changed is the one for the drive named in that same write. A read of this port reports the flag of the drive that is currently selected.

Top module: `fdc_port_bank`

## Requirements
- R1: After reset, `ctl_latch`, `mode_global`, `mode_drv` and `drv_sel` are all zero and `core_rst_pulse` is low.
- R2: A read of any address other than 0x090, 0x092, 0x094, 0x0BE and 0x4BE returns 0xFF. A write to such an address changes no output.
- R3: A read of 0x090 returns `core_msr`. A write to 0x090 raises no core strobe and changes no latched state.
- R4: A read of 0x092 asserts `core_data_rd` in the same cycle and returns `core_rdata`. A write to 0x092 asserts `core_data_wr` in the same cycle, with `core_wdata` equal to the bus write data. Neither strobe is high for any other access.
- R5: A read of 0x094 always returns 0x44, whatever has been written there.
- R6: A write to 0x094 stores the byte in `ctl_latch`. If bit 7 of the written byte is 1 while bit 7 of `ctl_latch` was 0, `core_rst_pulse` is high in the cycle after the write.
- R7: A write to 0x094 that leaves bit 7 at 1, or that clears it, produces no `core_rst_pulse`.
- R8: A write to 0x0BE loads `mode_global` from bit 1 of the written byte. A read of 0x0BE returns 0xFF when `mode_global` is 1 and 0xFD when it is 0.
- R9: Every write to 0x4BE loads `drv_sel` from bits 6:5 of the written byte.
- R10: When bit 4 of a byte written to 0x4BE is 1, bit 0 of that byte is stored into `mode_drv[n]`, where n is bits 6:5 of the same byte. The other drives' flags are unchanged. When bit 4 is 0, no flag changes.
- R11: A read of 0x4BE returns 0xFF when `mode_drv[drv_sel]` is 1 and 0xFE otherwise.
- R12: `core_rst_pulse` never stays high for two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Host I/O address |
| bus_rd | input | 1 | Host read strobe |
| bus_wr | input | 1 | Host write strobe |
| bus_wdata | input | 8 | Host write data |
| bus_rdata | output | 8 | Host read data (combinational) |
| core_msr | input | 8 | Main status byte from the controller core |
| core_rdata | input | 8 | Data register value from the controller core |
| core_data_rd | output | 1 | Data register read strobe to the core |
| core_data_wr | output | 1 | Data register write strobe to the core |
| core_wdata | output | 8 | Data register write value to the core |
| core_rst_pulse | output | 1 | One-cycle core reset and power-down release |
| ctl_latch | output | 8 | Last byte written to the control port |
| mode_global | output | 1 | Global density mode flag |
| mode_drv | output | 4 | Per-drive access-mode flags |
| drv_sel | output | 2 | Drive selected for flag read-back |

## Verification
The bound checker verifies the combinational behaviour on every cycle. This covers the fixed identification byte, the 0xFF answer for unmapped addresses, the status and data pass-through, and both flag read-back encodings. It also checks that the drive select follows each write to the flag port, that flags stay put without such a write, and that the reset pulse is a single cycle that only follows a 0-to-1 change of the control bit. Only the directed scenarios can show that the enable bit steers the flag value into the drive named in the same byte rather than into the previously selected drive. The same applies to repeated control writes with bit 7 already set, and to stray writes to the status port or unmapped addresses leaving every latched value intact.

// File: rtl/fdc_port_pkg.sv
package fdc_port_pkg;

    // Decoded port identity
    typedef enum logic [2:0] {
        PS_NONE,
        PS_STAT,
        PS_DATA,
        PS_CTL,
        PS_GLB,
        PS_DRV
    } port_sel_e;

    // Fixed read values
    localparam logic [7:0] RD_IDLE    = 8'hFF;
    localparam logic [7:0] RD_CTL_ID  = 8'h44;
    localparam logic [7:0] RD_GLB_OFF = 8'hFD;
    localparam logic [7:0] RD_DRV_OFF = 8'hFE;

    // Bit positions decoded by the port logic
    localparam int CTL_RST_BIT = 7;
    localparam int GLB_BIT     = 1;
    localparam int DRV_EN_BIT  = 4;
    localparam int DRV_VAL_BIT = 0;
    localparam int DRV_SEL_LSB = 5;

    // Control port state
    typedef struct packed {
        logic [7:0] ctl;
        logic       pulse;
    } ctl_st_t;

endpackage

// File: rtl/fdc_port_decode.sv
module fdc_port_decode
    import fdc_port_pkg::*;
#(
    parameter int              ADDR_W    = 12,
    parameter logic [ADDR_W-1:0] ADDR_STAT = 12'h090,
    parameter logic [ADDR_W-1:0] ADDR_DATA = 12'h092,
    parameter logic [ADDR_W-1:0] ADDR_CTL  = 12'h094,
    parameter logic [ADDR_W-1:0] ADDR_GLB  = 12'h0BE,
    parameter logic [ADDR_W-1:0] ADDR_DRV  = 12'h4BE
) (
    input  logic [ADDR_W-1:0] addr,
    output port_sel_e         sel
);

    always_comb begin
        sel = PS_NONE;
        if (addr == ADDR_STAT) sel = PS_STAT;
        if (addr == ADDR_DATA) sel = PS_DATA;
        if (addr == ADDR_CTL)  sel = PS_CTL;
        if (addr == ADDR_GLB)  sel = PS_GLB;
        if (addr == ADDR_DRV)  sel = PS_DRV;
    end

endmodule

// File: rtl/fdc_reset_ctl.sv
module fdc_reset_ctl
    import fdc_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] ctl_q,
    output logic       pulse_q
);

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (wr_en) begin
            st_d.ctl   = wdata;
            st_d.pulse = wdata[CTL_RST_BIT] & ~st_q.ctl[CTL_RST_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctl_q   = st_q.ctl;
    assign pulse_q = st_q.pulse;

endmodule

// File: rtl/fdc_mode_flags.sv
module fdc_mode_flags
    import fdc_port_pkg::*;
#(
    parameter int NUM_DRV = 4,
    localparam int SEL_W  = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               glb_wr,
    input  logic               drv_wr,
    input  logic [7:0]         wdata,
    output logic               glb_q,
    output logic [NUM_DRV-1:0] drv_q,
    output logic [SEL_W-1:0]   sel_q,
    output logic               cur_flag
);

    typedef struct packed {
        logic               glb;
        logic [SEL_W-1:0]   sel;
        logic [NUM_DRV-1:0] drv;
    } mode_st_t;

    mode_st_t st_d, st_q;

    logic [SEL_W-1:0]   wr_sel;
    logic               wr_en;
    logic [NUM_DRV-1:0] drv_next;

    assign wr_sel = wdata[DRV_SEL_LSB +: SEL_W];
    assign wr_en  = drv_wr & wdata[DRV_EN_BIT];

    // One update slice per drive flag
    for (genvar g = 0; g < NUM_DRV; g++) begin : g_drv
        localparam logic [SEL_W-1:0] IDX = SEL_W'(g);
        assign drv_next[g] = (wr_en && (wr_sel == IDX)) ? wdata[DRV_VAL_BIT]
                                                        : st_q.drv[g];
    end

    always_comb begin
        st_d     = st_q;
        st_d.drv = drv_next;
        if (glb_wr) begin
            st_d.glb = wdata[GLB_BIT];
        end
        if (drv_wr) begin
            st_d.sel = wr_sel;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign glb_q    = st_q.glb;
    assign drv_q    = st_q.drv;
    assign sel_q    = st_q.sel;
    assign cur_flag = st_q.drv[st_q.sel];

endmodule

// File: rtl/fdc_port_bank.sv
module fdc_port_bank
    import fdc_port_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                NUM_DRV   = 4,
    parameter logic [ADDR_W-1:0] ADDR_STAT = 12'h090,
    parameter logic [ADDR_W-1:0] ADDR_DATA = 12'h092,
    parameter logic [ADDR_W-1:0] ADDR_CTL  = 12'h094,
    parameter logic [ADDR_W-1:0] ADDR_GLB  = 12'h0BE,
    parameter logic [ADDR_W-1:0] ADDR_DRV  = 12'h4BE,
    localparam int               SEL_W     = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               bus_rd,
    input  logic               bus_wr,
    input  logic [7:0]         bus_wdata,
    output logic [7:0]         bus_rdata,
    input  logic [7:0]         core_msr,
    input  logic [7:0]         core_rdata,
    output logic               core_data_rd,
    output logic               core_data_wr,
    output logic [7:0]         core_wdata,
    output logic               core_rst_pulse,
    output logic [7:0]         ctl_latch,
    output logic               mode_global,
    output logic [NUM_DRV-1:0] mode_drv,
    output logic [SEL_W-1:0]   drv_sel
);

    port_sel_e psel;
    logic      cur_flag;

    fdc_port_decode #(
        .ADDR_W   (ADDR_W),
        .ADDR_STAT(ADDR_STAT),
        .ADDR_DATA(ADDR_DATA),
        .ADDR_CTL (ADDR_CTL),
        .ADDR_GLB (ADDR_GLB),
        .ADDR_DRV (ADDR_DRV)
    ) u_decode (
        .addr(bus_addr),
        .sel (psel)
    );

    fdc_reset_ctl u_rst (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (bus_wr && (psel == PS_CTL)),
        .wdata  (bus_wdata),
        .ctl_q  (ctl_latch),
        .pulse_q(core_rst_pulse)
    );

    fdc_mode_flags #(
        .NUM_DRV(NUM_DRV)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .glb_wr  (bus_wr && (psel == PS_GLB)),
        .drv_wr  (bus_wr && (psel == PS_DRV)),
        .wdata   (bus_wdata),
        .glb_q   (mode_global),
        .drv_q   (mode_drv),
        .sel_q   (drv_sel),
        .cur_flag(cur_flag)
    );

    // Core data pass-through
    assign core_data_rd = bus_rd && (psel == PS_DATA);
    assign core_data_wr = bus_wr && (psel == PS_DATA);
    assign core_wdata   = bus_wdata;

    // Read-back multiplexer
    always_comb begin
        bus_rdata = RD_IDLE;
        case (psel)
            PS_STAT: bus_rdata = core_msr;
            PS_DATA: bus_rdata = core_rdata;
            PS_CTL:  bus_rdata = RD_CTL_ID;
            PS_GLB:  bus_rdata = mode_global ? RD_IDLE : RD_GLB_OFF;
            PS_DRV:  bus_rdata = cur_flag ? RD_IDLE : RD_DRV_OFF;
            default: bus_rdata = RD_IDLE;
        endcase
    end

endmodule

// File: rtl/fdc_port_bank_chk.sv
module fdc_port_bank_chk
    import fdc_port_pkg::*;
#(
    parameter int                ADDR_W    = 12,
    parameter int                NUM_DRV   = 4,
    parameter logic [ADDR_W-1:0] ADDR_STAT = 12'h090,
    parameter logic [ADDR_W-1:0] ADDR_DATA = 12'h092,
    parameter logic [ADDR_W-1:0] ADDR_CTL  = 12'h094,
    parameter logic [ADDR_W-1:0] ADDR_GLB  = 12'h0BE,
    parameter logic [ADDR_W-1:0] ADDR_DRV  = 12'h4BE,
    localparam int               SEL_W     = (NUM_DRV > 1) ? $clog2(NUM_DRV) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic               bus_rd,
    input logic               bus_wr,
    input logic [7:0]         bus_wdata,
    input logic [7:0]         bus_rdata,
    input logic [7:0]         core_msr,
    input logic [7:0]         core_rdata,
    input logic               core_data_rd,
    input logic               core_data_wr,
    input logic               core_rst_pulse,
    input logic [7:0]         ctl_latch,
    input logic               mode_global,
    input logic [NUM_DRV-1:0] mode_drv,
    input logic [SEL_W-1:0]   drv_sel
);

    logic unmapped;
    assign unmapped = (bus_addr != ADDR_STAT) && (bus_addr != ADDR_DATA) &&
                      (bus_addr != ADDR_CTL)  && (bus_addr != ADDR_GLB)  &&
                      (bus_addr != ADDR_DRV);

    AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && unmapped) |-> (bus_rdata == 8'hFF)); // R2

    AST_STAT_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_STAT) |-> (!core_data_rd && !core_data_wr)); // R3

    AST_STAT_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_STAT) |-> (bus_rdata == core_msr)); // R3

    AST_DATA_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_DATA) |-> (core_data_rd && bus_rdata == core_rdata)); // R4

    AST_DATA_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DATA) |-> core_data_wr); // R4

    AST_ID_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_CTL) |-> (bus_rdata == 8'h44)); // R5

    AST_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_pulse |-> (ctl_latch[CTL_RST_BIT] && !$past(ctl_latch[CTL_RST_BIT]))); // R6

    AST_GLB_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_GLB) |-> (bus_rdata == (mode_global ? 8'hFF : 8'hFD))); // R8

    AST_SEL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_DRV) |=> (drv_sel == $past(bus_wdata[DRV_SEL_LSB +: SEL_W]))); // R9

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == ADDR_DRV && bus_wdata[DRV_EN_BIT]) |=> $stable(mode_drv)); // R10

    AST_DRV_RD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == ADDR_DRV) |-> (bus_rdata == (mode_drv[drv_sel] ? 8'hFF : 8'hFE))); // R11

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_rst_pulse |=> !core_rst_pulse); // R12

endmodule

bind fdc_port_bank fdc_port_bank_chk #(
    .ADDR_W   (ADDR_W),
    .NUM_DRV  (NUM_DRV),
    .ADDR_STAT(ADDR_STAT),
    .ADDR_DATA(ADDR_DATA),
    .ADDR_CTL (ADDR_CTL),
    .ADDR_GLB (ADDR_GLB),
    .ADDR_DRV (ADDR_DRV)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_rd        (bus_rd),
    .bus_wr        (bus_wr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .core_msr      (core_msr),
    .core_rdata    (core_rdata),
    .core_data_rd  (core_data_rd),
    .core_data_wr  (core_data_wr),
    .core_rst_pulse(core_rst_pulse),
    .ctl_latch     (ctl_latch),
    .mode_global   (mode_global),
    .mode_drv      (mode_drv),
    .drv_sel       (drv_sel)
);

// File: tb/fdc_port_bank_tb.sv
module fdc_port_bank_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  core_msr = '0;
    logic [7:0]  core_rdata = '0;
    logic        core_data_rd;
    logic        core_data_wr;
    logic [7:0]  core_wdata;
    logic        core_rst_pulse;
    logic [7:0]  ctl_latch;
    logic        mode_global;
    logic [3:0]  mode_drv;
    logic [1:0]  drv_sel;

    int checks = 0;
    int fails  = 0;

    // Captured during the strobe cycle of each access
    logic [7:0] rd_val;
    logic       cap_rd, cap_wr;
    logic [7:0] cap_wdata;

    always #2 clk = ~clk;

    fdc_port_bank u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_addr      (bus_addr),
        .bus_rd        (bus_rd),
        .bus_wr        (bus_wr),
        .bus_wdata     (bus_wdata),
        .bus_rdata     (bus_rdata),
        .core_msr      (core_msr),
        .core_rdata    (core_rdata),
        .core_data_rd  (core_data_rd),
        .core_data_wr  (core_data_wr),
        .core_wdata    (core_wdata),
        .core_rst_pulse(core_rst_pulse),
        .ctl_latch     (ctl_latch),
        .mode_global   (mode_global),
        .mode_drv      (mode_drv),
        .drv_sel       (drv_sel)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Write: drive at a falling edge, capture strobes, return after the rising edge
    task automatic bus_write(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        #1;
        cap_rd = core_data_rd; cap_wr = core_data_wr; cap_wdata = core_wdata;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 12'h000;
        #1;
    endtask

    task automatic bus_read(input logic [11:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        rd_val = bus_rdata; cap_rd = core_data_rd; cap_wr = core_data_wr;
        @(negedge clk);
        bus_rd = 1'b0; bus_addr = 12'h000;
        #1;
    endtask

    task automatic t_reset;
        chk("R1 ctl_latch", ctl_latch, 8'h00);
        chk("R1 mode_global", mode_global, 1'b0);
        chk("R1 mode_drv", mode_drv, 4'h0);
        chk("R1 drv_sel", drv_sel, 2'd0);
        chk("R1 pulse", core_rst_pulse, 1'b0);
        bus_read(12'h0BE); chk("R1 glb read", rd_val, 8'hFD);
        bus_read(12'h4BE); chk("R1 drv read", rd_val, 8'hFE);
    endtask

    task automatic t_unmapped;
        bus_read(12'h000); chk("R2 read 000", rd_val, 8'hFF);
        bus_read(12'h091); chk("R2 read 091", rd_val, 8'hFF);
        bus_read(12'h4BF); chk("R2 read 4BF", rd_val, 8'hFF);
        bus_read(12'hFFF); chk("R2 read FFF", rd_val, 8'hFF);
        bus_write(12'h0BF, 8'hFF);
        chk("R2 write no strobe", cap_wr, 1'b0);
        chk("R2 write ctl", ctl_latch, 8'h00);
        chk("R2 write drv", mode_drv, 4'h0);
        chk("R2 write glb", mode_global, 1'b0);
        chk("R2 write pulse", core_rst_pulse, 1'b0);
    endtask

    task automatic t_status;
        core_msr = 8'h5A;
        bus_read(12'h090);
        chk("R3 msr read", rd_val, 8'h5A);
        chk("R3 no data rd", cap_rd, 1'b0);
        core_msr = 8'hA1;
        bus_read(12'h090);
        chk("R3 msr read 2", rd_val, 8'hA1);
        bus_write(12'h090, 8'hFF);
        chk("R3 write no strobe", cap_wr, 1'b0);
        chk("R3 write ctl", ctl_latch, 8'h00);
        chk("R3 write glb", mode_global, 1'b0);
        chk("R3 write drv", mode_drv, 4'h0);
        chk("R3 write pulse", core_rst_pulse, 1'b0);
    endtask

    task automatic t_data;
        core_rdata = 8'hC3;
        bus_read(12'h092);
        chk("R4 data read", rd_val, 8'hC3);
        chk("R4 rd strobe", cap_rd, 1'b1);
        chk("R4 no wr strobe on read", cap_wr, 1'b0);
        bus_write(12'h092, 8'h37);
        chk("R4 wr strobe", cap_wr, 1'b1);
        chk("R4 wr data", cap_wdata, 8'h37);
        chk("R4 no rd strobe on write", cap_rd, 1'b0);
        chk("R4 strobes idle", {core_data_rd, core_data_wr}, 2'b00);
    endtask

    task automatic t_ctl;
        bus_read(12'h094); chk("R5 id read", rd_val, 8'h44);
        bus_write(12'h094, 8'h80);
        chk("R6 latch 80", ctl_latch, 8'h80);
        chk("R6 pulse after rise", core_rst_pulse, 1'b1);
        @(negedge clk); #1;
        chk("R12 pulse one cycle", core_rst_pulse, 1'b0);
        bus_read(12'h094); chk("R5 id read after write", rd_val, 8'h44);
        bus_write(12'h094, 8'h81);
        chk("R7 latch 81", ctl_latch, 8'h81);
        chk("R7 no pulse bit7 held", core_rst_pulse, 1'b0);
        bus_write(12'h094, 8'h00);
        chk("R7 latch 00", ctl_latch, 8'h00);
        chk("R7 no pulse bit7 fall", core_rst_pulse, 1'b0);
        bus_write(12'h094, 8'h7F);
        chk("R7 no pulse bit7 zero", core_rst_pulse, 1'b0);
        bus_write(12'h094, 8'hFF);
        chk("R6 latch FF", ctl_latch, 8'hFF);
        chk("R6 pulse second rise", core_rst_pulse, 1'b1);
        @(negedge clk); #1;
        chk("R12 pulse one cycle 2", core_rst_pulse, 1'b0);
    endtask

    task automatic t_global;
        bus_write(12'h0BE, 8'h02);
        chk("R8 global set", mode_global, 1'b1);
        bus_read(12'h0BE); chk("R8 read set", rd_val, 8'hFF);
        bus_write(12'h0BE, 8'hFD);
        chk("R8 global clear", mode_global, 1'b0);
        bus_read(12'h0BE); chk("R8 read clear", rd_val, 8'hFD);
    endtask

    task automatic t_drive;
        bus_write(12'h4BE, 8'h31);
        chk("R9 sel 1", drv_sel, 2'd1);
        chk("R10 set drv1", mode_drv, 4'b0010);
        bus_read(12'h4BE); chk("R11 read drv1", rd_val, 8'hFF);
        bus_write(12'h4BE, 8'h41);
        chk("R9 sel 2 no enable", drv_sel, 2'd2);
        chk("R10 no enable no change", mode_drv, 4'b0010);
        bus_read(12'h4BE); chk("R11 read drv2 clear", rd_val, 8'hFE);
        bus_write(12'h4BE, 8'h51);
        chk("R10 set drv2", mode_drv, 4'b0110);
        bus_write(12'h4BE, 8'h30);
        chk("R10 clear drv1 uses new sel", mode_drv, 4'b0100);
        chk("R9 sel back 1", drv_sel, 2'd1);
        bus_read(12'h4BE); chk("R11 read drv1 clear", rd_val, 8'hFE);
        bus_write(12'h4BE, 8'h71);
        chk("R10 set drv3", mode_drv, 4'b1100);
        bus_write(12'h4BE, 8'h11);
        chk("R10 set drv0", mode_drv, 4'b1101);
        bus_write(12'h4BE, 8'h40);
        bus_read(12'h4BE); chk("R11 read drv2 set", rd_val, 8'hFF);
        chk("R8 global untouched", mode_global, 1'b0);
    endtask

    initial begin : watchdog
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset();
        t_unmapped();
        t_status();
        t_data();
        t_ctl();
        t_global();
        t_drive();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule